// File: doc/BRIEF.md
# Hardware Thread Fork Allocator

This block serves a fork request in a processor that keeps several hardware thread contexts. The caller supplies a start address, a destination register index with the value to place in it, and its own virtual processor number, privilege mode and address-space identifier. The block looks at the state of every context in the configured range and picks the lowest-numbered one that is free. It then issues one set of write strobes that load that context's restart address, one of its general registers and its status fields. If no context is free, it reports a thread exception instead.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and all request fields must be stable during that cycle. The block checks the per-context state inputs in that same cycle and registers the outcome. Exactly one cycle after acceptance, either `done_o` or `fault_o` pulses for one cycle. `req_ready_o` is low during that pulse. The context register file applies the writes at the end of the pulse, so the next request always sees the updated state. A caller that keeps `req_valid_i` high simply waits that cycle.

Top module: `thread_fork_alloc`

## Requirements
- R1: Only contexts with index 0 through `cfg_last_ctx_i` are considered (the count is the field value plus one). A free context above that index is never selected.
- R2: When several contexts qualify, the lowest index is chosen. `sel_idx_o` gives that index, and `wr_sel_o` has exactly that bit set.
- R3: A context qualifies only if all four hold: its virtual processor number equals `req_vp_i`, its `ctx_dyn_i` bit is 1, its `ctx_halt_i` bit is 0, and its `ctx_active_i` bit is 0.
- R4: On success, `restart_pc_o` equals the accepted `req_pc_i`, `gpr_idx_o` equals `req_reg_i`, and `gpr_data_o` equals `req_data_i`.
- R5: On success, the status write carries run state 0 (`st_run_o` = 2'b00), delay-slot flag 0, dirty flag 1 and activated flag 1.
- R6: On success, `st_mode_o` equals the accepted `req_mode_i` and `st_asid_o` equals the accepted `req_asid_i`.
- R7: When nothing qualifies, `fault_o` and `exc_we_o` pulse, `exc_code_o` is 3'd1, and `wr_sel_o` is all zero.
- R8: `done_o` or `fault_o` pulses for exactly one cycle, one cycle after the accepting edge. The two are never high together.
- R9: `req_ready_o` is low in every cycle where `done_o` or `fault_o` is high, so a request held valid is taken again only one cycle later.
- R10: After reset, `done_o`, `fault_o` and `wr_sel_o` are 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Fork request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_pc_i | input | PC_W | Start address for the new thread |
| req_reg_i | input | REG_W | Destination general register index |
| req_data_i | input | DATA_W | Value for that register |
| req_vp_i | input | VP_W | Caller's virtual processor number |
| req_mode_i | input | MODE_W | Caller's privilege mode |
| req_asid_i | input | ASID_W | Caller's address-space identifier |
| cfg_last_ctx_i | input | CTX_W | Highest context index to scan |
| ctx_vp_i | input | NUM_CTX*VP_W | Per-context virtual processor binding, context k in bits [k*VP_W +: VP_W] |
| ctx_dyn_i | input | NUM_CTX | Per-context dynamically allocatable flag |
| ctx_halt_i | input | NUM_CTX | Per-context halt flag |
| ctx_active_i | input | NUM_CTX | Per-context activated flag |
| done_o | output | 1 | Successful fork, write strobe pulse |
| sel_idx_o | output | CTX_W | Chosen context index |
| wr_sel_o | output | NUM_CTX | One-hot write select of the chosen context |
| restart_pc_o | output | PC_W | Restart address to write |
| gpr_idx_o | output | REG_W | General register index to write |
| gpr_data_o | output | DATA_W | General register value to write |
| st_run_o | output | 2 | Run state to write |
| st_delay_o | output | 1 | Delay-slot flag to write |
| st_dirty_o | output | 1 | Dirty flag to write |
| st_active_o | output | 1 | Activated flag to write |
| st_mode_o | output | MODE_W | Privilege mode to write |
| st_asid_o | output | ASID_W | Address-space identifier to write |
| fault_o | output | 1 | Thread exception pulse |
| exc_we_o | output | 1 | Write strobe for the exception code |
| exc_code_o | output | 3 | Exception code value |

## Verification
Every result of a fork appears in the cycle after the accepting edge. This covers the done or fault pulse, the chosen index, the write select and all write data. The bench drives a request on a falling edge, lets one rising edge take it, and samples all outputs on the next falling edge. One sequence keeps `req_valid_i` high over four cycles. It expects the pulse pattern high, low, high, low, which shows the ready gap of R9. The falling edge after each pulse is also sampled to confirm that the pulse has ended.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int EXC_W = 3;
  localparam logic [EXC_W-1:0] EXC_NO_FREE_CTX = 3'd1;

  typedef struct packed {
    logic [1:0] run_state;
    logic       delay_slot;
    logic       dirty;
    logic       activated;
  } fork_flags_t;

  localparam fork_flags_t FORK_FLAGS_INIT = '{run_state: 2'b00, delay_slot: 1'b0,
                                              dirty: 1'b1, activated: 1'b1};
endpackage

// File: rtl/tfa_candidate.sv
module tfa_candidate #(
  parameter int NUM_CTX = 8,
  parameter int VP_W    = 4,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [CTX_W-1:0]        last_i,
  input  logic [VP_W-1:0]         caller_vp_i,
  input  logic [NUM_CTX*VP_W-1:0] ctx_vp_i,
  input  logic [NUM_CTX-1:0]      dyn_i,
  input  logic [NUM_CTX-1:0]      halt_i,
  input  logic [NUM_CTX-1:0]      active_i,
  output logic [NUM_CTX-1:0]      cand_o
);
  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic in_range;
    logic same_vp;
    assign in_range  = (CTX_W'(g) <= last_i);
    assign same_vp   = (ctx_vp_i[g*VP_W +: VP_W] == caller_vp_i);
    assign cand_o[g] = in_range & same_vp & dyn_i[g] & ~halt_i[g] & ~active_i[g];
  end
endmodule

// File: rtl/tfa_prio_enc.sv
module tfa_prio_enc #(
  parameter int NUM_CTX = 8,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX-1:0] req_i,
  output logic               found_o,
  output logic [CTX_W-1:0]   idx_o,
  output logic [NUM_CTX-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CTX_W'(i);
    end
  end

  assign onehot_o = req_i & (~req_i + NUM_CTX'(1));
  assign found_o  = |req_i;

  always_comb begin
    assert_enc_onehot_R2: assert (!found_o || (onehot_o[idx_o] && $onehot(onehot_o)));
  end
endmodule

// File: rtl/tfa_commit.sv
module tfa_commit
  import tfa_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int PC_W    = 32,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int MODE_W  = 2,
  parameter int ASID_W  = 8,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic               found_i,
  input  logic [CTX_W-1:0]   idx_i,
  input  logic [NUM_CTX-1:0] onehot_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [REG_W-1:0]   reg_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [ASID_W-1:0]  asid_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [CTX_W-1:0]   sel_idx_o,
  output logic [NUM_CTX-1:0] wr_sel_o,
  output logic [PC_W-1:0]    restart_pc_o,
  output logic [REG_W-1:0]   gpr_idx_o,
  output logic [DATA_W-1:0]  gpr_data_o,
  output fork_flags_t        flags_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic [ASID_W-1:0]  asid_o,
  output logic [EXC_W-1:0]   exc_code_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      sel_idx_o    <= '0;
      wr_sel_o     <= '0;
      restart_pc_o <= '0;
      gpr_idx_o    <= '0;
      gpr_data_o   <= '0;
      flags_o      <= '0;
      mode_o       <= '0;
      asid_o       <= '0;
      exc_code_o   <= '0;
    end else begin
      done_o   <= take_i & found_i;
      fault_o  <= take_i & ~found_i;
      wr_sel_o <= (take_i && found_i) ? onehot_i : '0;
      if (take_i) begin
        sel_idx_o    <= idx_i;
        restart_pc_o <= pc_i;
        gpr_idx_o    <= reg_i;
        gpr_data_o   <= data_i;
        flags_o      <= FORK_FLAGS_INIT;
        mode_o       <= mode_i;
        asid_o       <= asid_i;
        exc_code_o   <= found_i ? '0 : EXC_NO_FREE_CTX;
      end
    end
  end

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  assert_fault_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (wr_sel_o == '0 && exc_code_o == EXC_NO_FREE_CTX));
  assert_done_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($onehot(wr_sel_o) && wr_sel_o[sel_idx_o]));
  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && found_i) |=> done_o);
  assert_pc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (restart_pc_o == $past(pc_i) && gpr_data_o == $past(data_i)));
endmodule

// File: rtl/thread_fork_alloc.sv
module thread_fork_alloc
  import tfa_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int PC_W    = 32,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int VP_W    = 4,
  parameter int MODE_W  = 2,
  parameter int ASID_W  = 8,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [PC_W-1:0]         req_pc_i,
  input  logic [REG_W-1:0]        req_reg_i,
  input  logic [DATA_W-1:0]       req_data_i,
  input  logic [VP_W-1:0]         req_vp_i,
  input  logic [MODE_W-1:0]       req_mode_i,
  input  logic [ASID_W-1:0]       req_asid_i,
  input  logic [CTX_W-1:0]        cfg_last_ctx_i,
  input  logic [NUM_CTX*VP_W-1:0] ctx_vp_i,
  input  logic [NUM_CTX-1:0]      ctx_dyn_i,
  input  logic [NUM_CTX-1:0]      ctx_halt_i,
  input  logic [NUM_CTX-1:0]      ctx_active_i,
  output logic                    done_o,
  output logic [CTX_W-1:0]        sel_idx_o,
  output logic [NUM_CTX-1:0]      wr_sel_o,
  output logic [PC_W-1:0]         restart_pc_o,
  output logic [REG_W-1:0]        gpr_idx_o,
  output logic [DATA_W-1:0]       gpr_data_o,
  output logic [1:0]              st_run_o,
  output logic                    st_delay_o,
  output logic                    st_dirty_o,
  output logic                    st_active_o,
  output logic [MODE_W-1:0]       st_mode_o,
  output logic [ASID_W-1:0]       st_asid_o,
  output logic                    fault_o,
  output logic                    exc_we_o,
  output logic [EXC_W-1:0]        exc_code_o
);
  logic [NUM_CTX-1:0] cand;
  logic [NUM_CTX-1:0] onehot;
  logic [CTX_W-1:0]   first_idx;
  logic               any_free;
  logic               take;
  fork_flags_t        flags;

  assign req_ready_o = ~(done_o | fault_o);
  assign take        = req_valid_i & req_ready_o;

  tfa_candidate #(.NUM_CTX(NUM_CTX), .VP_W(VP_W)) u_cand (
    .last_i     (cfg_last_ctx_i),
    .caller_vp_i(req_vp_i),
    .ctx_vp_i   (ctx_vp_i),
    .dyn_i      (ctx_dyn_i),
    .halt_i     (ctx_halt_i),
    .active_i   (ctx_active_i),
    .cand_o     (cand)
  );

  tfa_prio_enc #(.NUM_CTX(NUM_CTX)) u_enc (
    .req_i   (cand),
    .found_o (any_free),
    .idx_o   (first_idx),
    .onehot_o(onehot)
  );

  tfa_commit #(
    .NUM_CTX(NUM_CTX), .PC_W(PC_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .MODE_W(MODE_W), .ASID_W(ASID_W)
  ) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .found_i     (any_free),
    .idx_i       (first_idx),
    .onehot_i    (onehot),
    .pc_i        (req_pc_i),
    .reg_i       (req_reg_i),
    .data_i      (req_data_i),
    .mode_i      (req_mode_i),
    .asid_i      (req_asid_i),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .sel_idx_o   (sel_idx_o),
    .wr_sel_o    (wr_sel_o),
    .restart_pc_o(restart_pc_o),
    .gpr_idx_o   (gpr_idx_o),
    .gpr_data_o  (gpr_data_o),
    .flags_o     (flags),
    .mode_o      (st_mode_o),
    .asid_o      (st_asid_o),
    .exc_code_o  (exc_code_o)
  );

  assign st_run_o    = flags.run_state;
  assign st_delay_o  = flags.delay_slot;
  assign st_dirty_o  = flags.dirty;
  assign st_active_o = flags.activated;
  assign exc_we_o    = fault_o;

  assert_ready_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !req_ready_o);
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !(done_o || fault_o));
  assert_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (!done_o || sel_idx_o <= $past(cfg_last_ctx_i)));
  assert_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (st_mode_o == $past(req_mode_i) && st_asid_o == $past(req_asid_i)));
  assert_qualify_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && any_free) |-> (ctx_dyn_i[first_idx] && !ctx_halt_i[first_idx]
                            && !ctx_active_i[first_idx]));
endmodule

// File: tb/thread_fork_alloc_tb.sv
`timescale 1ns/1ps
module thread_fork_alloc_tb;
  localparam int N = 8;
  localparam int CW = 3;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_pc = '0;
  logic [4:0]    req_reg = '0;
  logic [31:0]   req_data = '0;
  logic [VW-1:0] req_vp = '0;
  logic [1:0]    req_mode = '0;
  logic [7:0]    req_asid = '0;
  logic [CW-1:0] cfg_last = 3'd7;
  logic [N*VW-1:0] ctx_vp = '0;
  logic [N-1:0]  ctx_dyn = '0, ctx_halt = '0, ctx_active = '0;
  logic          done, fault, exc_we;
  logic [CW-1:0] sel_idx;
  logic [N-1:0]  wr_sel;
  logic [31:0]   restart_pc, gpr_data;
  logic [4:0]    gpr_idx;
  logic [1:0]    st_run, st_mode;
  logic          st_delay, st_dirty, st_active;
  logic [7:0]    st_asid;
  logic [2:0]    exc_code;

  thread_fork_alloc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pc_i(req_pc), .req_reg_i(req_reg), .req_data_i(req_data), .req_vp_i(req_vp),
    .req_mode_i(req_mode), .req_asid_i(req_asid), .cfg_last_ctx_i(cfg_last),
    .ctx_vp_i(ctx_vp), .ctx_dyn_i(ctx_dyn), .ctx_halt_i(ctx_halt), .ctx_active_i(ctx_active),
    .done_o(done), .sel_idx_o(sel_idx), .wr_sel_o(wr_sel), .restart_pc_o(restart_pc),
    .gpr_idx_o(gpr_idx), .gpr_data_o(gpr_data), .st_run_o(st_run), .st_delay_o(st_delay),
    .st_dirty_o(st_dirty), .st_active_o(st_active), .st_mode_o(st_mode), .st_asid_o(st_asid),
    .fault_o(fault), .exc_we_o(exc_we), .exc_code_o(exc_code)
  );

  int total = 0;
  int bad = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick();
    for (int i = 0; i < N; i++) begin
      if (i <= int'(cfg_last) && ctx_vp[i*VW +: VW] == req_vp && ctx_dyn[i]
          && !ctx_halt[i] && !ctx_active[i]) return i;
    end
    return -1;
  endfunction

  task automatic set_all(input logic [VW-1:0] vp, input logic dyn, input logic h, input logic a);
    for (int i = 0; i < N; i++) ctx_vp[i*VW +: VW] = vp;
    ctx_dyn = {N{dyn}}; ctx_halt = {N{h}}; ctx_active = {N{a}};
  endtask

  // Drive on a falling edge, accept at the next rising edge, check one falling edge later.
  task automatic do_fork(string tag);
    int exp_idx;
    logic [31:0] pc_s, data_s; logic [4:0] reg_s; logic [1:0] mode_s; logic [7:0] asid_s;
    req_pc = $urandom; req_data = $urandom; req_reg = 5'($urandom);
    req_mode = 2'($urandom); req_asid = 8'($urandom);
    pc_s = req_pc; data_s = req_data; reg_s = req_reg; mode_s = req_mode; asid_s = req_asid;
    exp_idx = model_pick();
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (exp_idx >= 0) begin
      check({tag, " R8 done"}, 64'(done), 64'd1);
      check({tag, " R8 fault"}, 64'(fault), 64'd0);
      check({tag, " R2 idx"}, 64'(sel_idx), 64'(exp_idx));
      check({tag, " R2 wr_sel"}, 64'(wr_sel), 64'(N'(1) << exp_idx));
      check({tag, " R4 pc"}, 64'(restart_pc), 64'(pc_s));
      check({tag, " R4 gpr"}, {27'd0, gpr_idx, gpr_data}, {27'd0, reg_s, data_s});
      check({tag, " R5 flags"}, {59'd0, st_run, st_delay, st_dirty, st_active},
            {59'd0, 2'b00, 1'b0, 1'b1, 1'b1});
      check({tag, " R6 mode/asid"}, {54'd0, st_mode, st_asid}, {54'd0, mode_s, asid_s});
    end else begin
      check({tag, " R7 fault"}, {62'd0, fault, exc_we}, {62'd0, 2'b11});
      check({tag, " R7 done"}, 64'(done), 64'd0);
      check({tag, " R7 code"}, 64'(exc_code), 64'd1);
      check({tag, " R7 wr_sel"}, 64'(wr_sel), 64'd0);
    end
    check({tag, " R9 ready"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    check({tag, " R8 pulse end"}, {62'd0, done, fault}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset done/fault", {62'd0, done, fault}, 64'd0);
    check("R10 reset wr_sel", 64'(wr_sel), 64'd0);
    check("R10 reset ready", 64'(req_ready), 64'd1);

    // R2: all free, lowest chosen
    req_vp = 4'd2; cfg_last = 3'd7; set_all(4'd2, 1, 0, 0);
    do_fork("dir all-free R2");
    // R3: skip other VP bindings
    ctx_vp[0*VW +: VW] = 4'd5; ctx_vp[1*VW +: VW] = 4'd3;
    do_fork("dir other-vp R3");
    // R3: each disqualifier alone
    set_all(4'd2, 1, 0, 0); ctx_dyn[0] = 1'b0; ctx_halt[1] = 1'b1; ctx_active[2] = 1'b1;
    do_fork("dir disq R3");
    // R7: all busy
    set_all(4'd2, 1, 0, 1);
    do_fork("dir busy R7");
    // R1: only context 5 free, range ends at 1
    ctx_active[5] = 1'b0; cfg_last = 3'd1;
    do_fork("dir range R1");
    cfg_last = 3'd5;
    do_fork("dir range-edge R1");

    // R9: valid held high, expect pulses high, low, high, low
    set_all(4'd2, 1, 0, 0); cfg_last = 3'd7;
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk); check("R9 hold c1", 64'(done), 64'd1);
    @(negedge clk); check("R9 hold c2", 64'(done), 64'd0);
    @(negedge clk); check("R9 hold c3", 64'(done), 64'd1);
    req_valid = 1'b0;
    @(negedge clk); check("R9 hold c4", 64'(done), 64'd0);

    for (int t = 0; t < 300; t++) begin
      req_vp = 4'($urandom_range(0, 3));
      cfg_last = 3'($urandom_range(0, 7));
      for (int i = 0; i < N; i++) begin
        ctx_vp[i*VW +: VW] = 4'($urandom_range(0, 3));
        ctx_dyn[i]    = ($urandom_range(0, 3) != 0);
        ctx_halt[i]   = ($urandom_range(0, 3) == 0);
        ctx_active[i] = ($urandom_range(0, 4) < 2);
      end
      do_fork("rand R1 R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule